// File: doc/BRIEF.md
# Two-Lane Limb Carry Reducer for the 2^255-19 Field

This block takes field elements of the prime field with p = 2^255 - 19 that arrive as ten wide unsigned accumulator limbs. Such limbs are what a multiply-accumulate step leaves behind. The block hands each element back with every limb trimmed to about its nominal width. Limb k has the nominal width w_k = 26 when k is even and 25 when k is odd. Limb k therefore carries the weight 2^o_k, where o_k = ceil(25.5*k), so o_k runs 0, 26, 51, 77, 102, 128, 153, 179, 204, 230. Two independent lanes are handled side by side.

Carries are not rippled through one long chain. Two chains run interleaved instead: one goes from limb 0 up to limb 6, and the other goes from limb 5 through limb 9, wraps round into limb 0 and ends in limb 1. When a carry leaves limb 9 it is multiplied by 19 before it enters limb 0, because 2^255 is congruent to 19 modulo p. The pipeline has six stages, and each stage applies one carry from each chain. A new element can be accepted on every clock cycle. The output is reduced but not canonical: it may still be greater than or equal to p.

Top module: `fe_carry_reducer`

## Requirements
- R1: A carry from limb k (k below 9) shifts limb k logically right by w_k, adds the shifted value into limb k+1 and keeps only the low w_k bits in limb k.
- R2: A carry from limb 9 shifts it logically right by 25, multiplies that value by 19, adds it into limb 0 and keeps the low 25 bits of limb 9.
- R3: Carries are applied in six ordered steps. Step s (s = 0..5) applies the carry from limb s and the carry from limb (s+5) mod 10. For a given input, the output limbs are exactly those that this sequence produces.
- R4: For each lane, the weighted sum of the limbs (limb k times 2^o_k) is the same modulo p at the output as at the input.
- R5: Every input limb is below 2^62. Under that condition, output limbs 0, 2, 3, 4, 5, 7, 8 and 9 are below 2^w_k, and limbs 1 and 6 are below 2^(w_k+1).
- R6: out_valid goes high exactly six cycles after a cycle in which in_valid is high, and stays low otherwise. One element is accepted on every cycle, with no stall.
- R7: The lanes are independent. Bits [l*640 + k*64 +: 64] of each limb bus hold limb k of lane l, and output lane l depends only on input lane l.
- R8: The reset is synchronous and active high. One cycle later, out_valid is 0 and every output limb is 0, and any element still in flight is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input element valid |
| in_limbs | input | 1280 | Two lanes of ten 64-bit unsigned limbs |
| out_valid | output | 1 | Reduced element valid |
| out_limbs | output | 1280 | Two lanes of ten reduced limbs |

## Verification
On every cycle, the assertions check the following. Each carry step leaves the exact weighted amount unchanged across its pair of limbs. The wrap step trades 19 times the value removed from limb 9 against what limb 0 gains. Each limb that sends a carry ends up within its nominal width. Valid moves forward one stage per cycle, inputs stay within their headroom, and outputs stay within their bounds. Some behaviour only the scenarios can show: the exact ordering of the steps (through carry-propagation cases worked out by hand, among them a ripple across six limbs), invariance modulo p on random streams with gaps, the separation of the lanes, and the clearing of elements in flight by a reset.

// File: rtl/fe_carry_pkg.sv
package fe_carry_pkg;

    localparam int NLIMB         = 10;
    localparam int LIMB_W        = 64;
    localparam int WRAP_MUL      = 19;
    localparam int N_STEPS       = 6;
    localparam int CHAIN_B_START = 5;
    localparam int IN_HEADROOM   = 62;

    typedef logic [LIMB_W-1:0] limb_t;
    typedef limb_t [NLIMB-1:0] fe_t;
    typedef logic [127:0]      wide_t;

    // Nominal width of a limb: 26 bits for even indices, 25 bits for odd ones
    function automatic int nominal_w(int k);
        return ((k % 2) == 0) ? 26 : 25;
    endfunction

    function automatic int next_idx(int k);
        return (k + 1) % NLIMB;
    endfunction

    // Source limb of the given chain (0 or 1) at the given step
    function automatic int chain_src(int chain, int step);
        return (chain == 0) ? step : (CHAIN_B_START + step) % NLIMB;
    endfunction

    // Limb that receives the last carry of a chain
    function automatic int last_dst(int chain);
        return next_idx(chain_src(chain, N_STEPS - 1));
    endfunction

    // One carry out of limb k; the carry out of the top limb is scaled by 19
    function automatic fe_t carry_once(fe_t x, int k);
        fe_t   y;
        limb_t c;
        y = x;
        c = x[k] >> nominal_w(k);
        if (k == NLIMB - 1)
            c = c * limb_t'(WRAP_MUL);
        y[k]           = x[k] & ((limb_t'(1) << nominal_w(k)) - limb_t'(1));
        y[next_idx(k)] = x[next_idx(k)] + c;
        return y;
    endfunction

    function automatic bit fe_in_headroom(fe_t x);
        for (int k = 0; k < NLIMB; k++)
            if ((x[k] >> IN_HEADROOM) != '0) return 1'b0;
        return 1'b1;
    endfunction

    function automatic bit fe_out_bounded(fe_t x);
        for (int k = 0; k < NLIMB; k++) begin
            int w;
            w = nominal_w(k);
            if (k == last_dst(0) || k == last_dst(1)) w = w + 1;
            if ((x[k] >> w) != '0) return 1'b0;
        end
        return 1'b1;
    endfunction

endpackage

// File: rtl/fecr_lane_step.sv
module fecr_lane_step
    import fe_carry_pkg::*;
#(
    parameter int SRC_A = 0,
    parameter int SRC_B = 5
) (
    input  fe_t d_i,
    output fe_t d_o
);
    fe_t mid;

    // The two carries of one step touch disjoint limb pairs
    always_comb begin
        mid = carry_once(d_i, SRC_A);
        d_o = carry_once(mid, SRC_B);
    end

endmodule

// File: rtl/fecr_stage.sv
module fecr_stage
    import fe_carry_pkg::*;
#(
    parameter int NLANE = 2,
    parameter int SRC_A = 0,
    parameter int SRC_B = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             vld_i,
    input  fe_t [NLANE-1:0]  d_i,
    output logic             vld_o,
    output fe_t [NLANE-1:0]  d_o
);
    fe_t [NLANE-1:0] nxt;

    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        fecr_lane_step #(.SRC_A(SRC_A), .SRC_B(SRC_B)) i_step (
            .d_i (d_i[l]),
            .d_o (nxt[l])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o <= 1'b0;
            d_o   <= '0;
        end else begin
            vld_o <= vld_i;
            d_o   <= nxt;
        end
    end

    // R6
    vld_fwd_chk: assert property (@(posedge clk) disable iff (rst)
        vld_i |=> vld_o);
    // R6
    vld_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !vld_i |=> !vld_o);

    for (genvar l = 0; l < NLANE; l++) begin : g_chk_lane
        for (genvar c = 0; c < 2; c++) begin : g_chk_chain
            localparam int S = (c == 0) ? SRC_A : SRC_B;
            localparam int D = next_idx(S);
            // R1
            src_trim_chk: assert property (@(posedge clk) disable iff (rst)
                vld_o |-> (d_o[l][S] >> nominal_w(S)) == '0);
            if (S == NLIMB - 1) begin : g_wrap
                // R2
                wrap_balance_chk: assert property (@(posedge clk) disable iff (rst)
                    vld_o |-> (wide_t'(WRAP_MUL) * (wide_t'($past(d_i[l][S])) - wide_t'(d_o[l][S])))
                              == ((wide_t'(d_o[l][D]) - wide_t'($past(d_i[l][D]))) << nominal_w(S)));
            end else begin : g_lin
                // R1
                step_balance_chk: assert property (@(posedge clk) disable iff (rst)
                    vld_o |-> (wide_t'(d_o[l][S]) + (wide_t'(d_o[l][D]) << nominal_w(S)))
                              == (wide_t'($past(d_i[l][S])) + (wide_t'($past(d_i[l][D])) << nominal_w(S))));
            end
        end
    end

endmodule

// File: rtl/fe_carry_reducer.sv
module fe_carry_reducer
    import fe_carry_pkg::*;
#(
    parameter int NLANE = 2
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   in_valid,
    input  logic [NLANE-1:0][NLIMB-1:0][LIMB_W-1:0] in_limbs,
    output logic                                   out_valid,
    output logic [NLANE-1:0][NLIMB-1:0][LIMB_W-1:0] out_limbs
);
    logic            vld_s [N_STEPS+1];
    fe_t [NLANE-1:0] dat_s [N_STEPS+1];

    assign vld_s[0] = in_valid;
    assign dat_s[0] = in_limbs;

    // Step s carries out of limb s (chain A) and limb s+5 mod 10 (chain B)
    for (genvar s = 0; s < N_STEPS; s++) begin : g_step
        fecr_stage #(
            .NLANE (NLANE),
            .SRC_A (chain_src(0, s)),
            .SRC_B (chain_src(1, s))
        ) i_stage (
            .clk   (clk),
            .rst   (rst),
            .vld_i (vld_s[s]),
            .d_i   (dat_s[s]),
            .vld_o (vld_s[s+1]),
            .d_o   (dat_s[s+1])
        );
    end

    assign out_valid = vld_s[N_STEPS];
    assign out_limbs = dat_s[N_STEPS];

    for (genvar l = 0; l < NLANE; l++) begin : g_lane_chk
        // R5
        in_headroom_chk: assert property (@(posedge clk) disable iff (rst)
            in_valid |-> fe_in_headroom(in_limbs[l]));
        // R5
        out_bound_chk: assert property (@(posedge clk) disable iff (rst)
            out_valid |-> fe_out_bounded(out_limbs[l]));
    end

endmodule

// File: tb/test_fe_carry_reducer.sv
`timescale 1ns/1ps
module test_fe_carry_reducer;
    import fe_carry_pkg::*;

    localparam int NL  = 2;
    localparam int LAT = 6;
    localparam int QD  = 64;
    localparam int NV  = 9;
    localparam logic [319:0] PRIME = (320'd1 << 255) - 320'd19;

    typedef struct packed {
        fe_t        din;
        fe_t        dout;
        logic [3:0] rq;
    } vec_t;

    // Hand-worked carry cases; rq names the requirement (R1 shift/mask,
    // R2 wrap by 19, R3 full step ordering)
    localparam vec_t TABLE [NV] = '{
        '{din: '{default: 64'h0}, dout: '{default: 64'h0}, rq: 4'd3},
        '{din: '{0: 64'h400_0000, default: 64'h0}, dout: '{1: 64'h1, default: 64'h0}, rq: 4'd1},
        '{din: '{9: 64'h200_0000, default: 64'h0}, dout: '{0: 64'd19, default: 64'h0}, rq: 4'd2},
        '{din: '{0: 64'h400_0000, 1: 64'h1FF_FFFF, 2: 64'h3FF_FFFF, 3: 64'h1FF_FFFF, 4: 64'h3FF_FFFF,
                 5: 64'h1FF_FFFF, 6: 64'h3FF_FFFF, 7: 64'h1FF_FFFF, 8: 64'h3FF_FFFF, 9: 64'h1FF_FFFF},
          dout: '{6: 64'h400_0000, 7: 64'h1FF_FFFF, 8: 64'h3FF_FFFF, 9: 64'h1FF_FFFF, default: 64'h0},
          rq: 4'd3},
        '{din: '{8: 64'h400_0000, default: 64'h0}, dout: '{9: 64'h1, default: 64'h0}, rq: 4'd1},
        '{din: '{4: 64'h1_0000_0000, default: 64'h0}, dout: '{5: 64'd64, default: 64'h0}, rq: 4'd1},
        '{din: '{5: 64'h4000_0000, default: 64'h0}, dout: '{6: 64'd32, default: 64'h0}, rq: 4'd1},
        '{din: '{9: 64'h4_0000_0000_0000, default: 64'h0},
          dout: '{0: 64'h200_0000, 1: 64'd9, default: 64'h0}, rq: 4'd2},
        '{din: '{3: 64'hA00_0007, default: 64'h0}, dout: '{3: 64'd7, 4: 64'd5, default: 64'h0}, rq: 4'd1}
    };

    logic                             clk = 1'b0;
    logic                             rst;
    logic                             in_valid;
    logic [NL-1:0][NLIMB-1:0][63:0]   in_limbs;
    logic                             out_valid;
    logic [NL-1:0][NLIMB-1:0][63:0]   out_limbs;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    fe_carry_reducer #(.NLANE(NL)) i_fe_carry_reducer (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_limbs  (in_limbs),
        .out_valid (out_valid),
        .out_limbs (out_limbs)
    );

    function automatic logic [319:0] fe_value(fe_t x);
        logic [319:0] acc;
        acc = '0;
        for (int k = 0; k < NLIMB; k++)
            acc = acc + ({256'd0, x[k]} << ((51 * k + 1) / 2));
        return acc % PRIME;
    endfunction

    // R5 bounds as stated: limbs 1 and 6 get one bit of slack
    function automatic bit bound_ok(fe_t x);
        for (int k = 0; k < NLIMB; k++) begin
            int w;
            w = ((k % 2) == 0) ? 26 : 25;
            if (k == 1 || k == 6) w = w + 1;
            if ((x[k] >> w) != 64'd0) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic check(bit ok, string req, string what, logic [639:0] act, logic [639:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Expected-result queue filled and drained by the monitor
    fe_t [NL-1:0] q_in  [QD];
    fe_t [NL-1:0] q_exp [QD];
    bit           q_has [QD];
    int           q_rq  [QD];
    int           wp = 0;
    int           rp = 0;
    bit [LAT-2:0] hist = '0;

    fe_t [NL-1:0] cur_exp;
    bit           cur_has;
    int           cur_rq;

    always @(posedge clk) begin
        #1;
        if (rst) begin
            check(!out_valid && out_limbs == '0, "R8", "reset clears outputs",
                  {639'd0, out_valid}, 640'd0);
            hist = '0;
            wp   = 0;
            rp   = 0;
        end else begin
            if (out_valid || hist[LAT-2])
                check(out_valid == hist[LAT-2], "R6", "six-cycle valid",
                      {639'd0, out_valid}, {639'd0, hist[LAT-2]});
            if (out_valid && rp != wp) begin
                for (int l = 0; l < NL; l++) begin
                    fe_t o;
                    o = out_limbs[l];
                    check(fe_value(o) == fe_value(q_in[rp % QD][l]), "R4", "value mod p",
                          {320'd0, fe_value(o)}, {320'd0, fe_value(q_in[rp % QD][l])});
                    check(bound_ok(o), "R5", "limb bounds", o, 640'd0);
                    if (q_has[rp % QD])
                        check(o == q_exp[rp % QD][l],
                              (l == 0) ? $sformatf("R%0d", q_rq[rp % QD]) : "R7",
                              $sformatf("exact limbs lane %0d", l), o, q_exp[rp % QD][l]);
                end
                rp++;
            end
            hist = {hist[LAT-3:0], in_valid};
            if (in_valid) begin
                q_in[wp % QD]  = in_limbs;
                q_exp[wp % QD] = cur_exp;
                q_has[wp % QD] = cur_has;
                q_rq[wp % QD]  = cur_rq;
                wp++;
            end
        end
    end

    task automatic send(bit v, fe_t [NL-1:0] d, fe_t [NL-1:0] e, bit has, int rq);
        @(negedge clk);
        in_valid = v;
        in_limbs = d;
        cur_exp  = e;
        cur_has  = has;
        cur_rq   = rq;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) send(1'b0, '0, '0, 1'b0, 0);
    endtask

    logic [63:0] rs = 64'h9E37_79B9_7F4A_7C15;
    function automatic logic [63:0] rnd();
        rs = rs ^ (rs << 13);
        rs = rs ^ (rs >> 7);
        rs = rs ^ (rs << 17);
        return rs;
    endfunction

    initial begin
        repeat (5000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        fe_t [NL-1:0] d;
        fe_t [NL-1:0] e;
        rst      = 1'b1;
        in_valid = 1'b0;
        in_limbs = '0;
        cur_exp  = '0;
        cur_has  = 1'b0;
        cur_rq   = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // Table walk, back to back; lane 1 takes the next entry (R7)
        for (int k = 0; k < NV; k++) begin
            d[0] = TABLE[k].din;
            e[0] = TABLE[k].dout;
            d[1] = TABLE[(k + 1) % NV].din;
            e[1] = TABLE[(k + 1) % NV].dout;
            send(1'b1, d, e, 1'b1, int'(TABLE[k].rq));
        end
        idle(8);

        // Single element after idle: R6 latency
        d[0] = TABLE[7].din;  e[0] = TABLE[7].dout;
        d[1] = TABLE[3].din;  e[1] = TABLE[3].dout;
        send(1'b1, d, e, 1'b1, 2);
        idle(9);

        // Largest allowed limbs on both lanes (R5)
        for (int l = 0; l < NL; l++)
            for (int k = 0; k < NLIMB; k++)
                d[l][k] = (64'd1 << 62) - 64'd1;
        send(1'b1, d, '0, 1'b0, 0);

        // Random stream with gaps (R4, R5, R6)
        for (int i = 0; i < 80; i++) begin
            logic [63:0] r;
            for (int l = 0; l < NL; l++)
                for (int k = 0; k < NLIMB; k++) begin
                    r = rnd();
                    d[l][k] = r >> (2 + (r[5:0] % 40));
                end
            r = rnd();
            send(r[7] | r[3], d, '0, 1'b0, 0);
        end
        idle(8);

        // Reset while elements are in flight (R8)
        for (int i = 0; i < 3; i++) begin
            d[0] = TABLE[i + 1].din;
            d[1] = TABLE[i + 4].din;
            send(1'b1, d, '0, 1'b0, 0);
        end
        @(negedge clk);
        in_valid = 1'b0;
        rst      = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        idle(8);

        // Recovery after reset (R3)
        d[0] = TABLE[3].din;  e[0] = TABLE[3].dout;
        d[1] = TABLE[8].din;  e[1] = TABLE[8].dout;
        send(1'b1, d, e, 1'b1, 3);
        idle(10);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule